// File: doc/BRIEF.md
# Trigger Type Queue and Serializer

This block accepts an 8-bit trigger-type value that shows up some microseconds after the trigger it belongs to. The arrival time has no fixed relation to the machine cycle. The block widens each value to a 10-bit word by adding two reserved bits, which are always zero, above the type byte. It holds the words in a first-in first-out queue, so they leave in the order the triggers arrived. Each word then goes out as a framed serial stream on a dedicated line.

That line carries only trigger types. The slow, late-arriving type data therefore never stalls or delays the stream that carries event and crossing identifiers. During rapid triggering, the queue absorbs bursts so that no word is lost. If the queue does fill, a sticky flag records that a word was dropped.

Top module: `trig_type_tx`

## Requirements
- R1: While reset is asserted, and right after it, `ser_out` is 1, `q_empty` is 1, and `q_full`, `overflow` and `tx_busy` are 0.
- R2: When no frame is being sent, `ser_out` holds the idle level 1.
- R3: The transmitted 10-bit word is the type byte in bits 7..0, with bits 9..8 (reserved) sent as zero.
- R4: A frame is one start bit at 0, then the 10 word bits most significant first, then one stop bit at 1. Each bit lasts `BIT_CYCLES` clock cycles, so `tx_busy` stays high for 12*`BIT_CYCLES` cycles.
- R5: Words are transmitted in the same order as the strobes that delivered them.
- R6: The queue holds `DEPTH` words in addition to the word being sent. `q_full` is 1 exactly when `DEPTH` words wait. No word is lost while the queue is not full, including on strobes in consecutive cycles.
- R7: A strobe that arrives while `q_full` is 1 is dropped. It sets `overflow`, which stays 1 until reset. The dropped word is never transmitted, and the queued words are not affected.
- R8: When the line is idle and the queue is empty, a strobe sampled on a clock edge puts the start bit on `ser_out` after the following edge. Whenever a word waits and no frame is in progress, a frame starts on the next edge.
- R9: A new frame starts only after the stop bit of the previous frame has finished. Back-to-back frames have start bits exactly 12*`BIT_CYCLES`+1 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| type_valid | input | 1 | Strobe: `type_byte` holds a new trigger type |
| type_byte | input | 8 | Trigger-type value from the central trigger |
| ser_out | output | 1 | Serial frame line, idle high |
| tx_busy | output | 1 | A frame is in progress |
| q_empty | output | 1 | No word waiting in the queue |
| q_full | output | 1 | Queue holds `DEPTH` waiting words |
| overflow | output | 1 | Sticky: a word was dropped because the queue was full |

## Verification
The assertions check the following on every cycle: the idle level, that each frame opens low, the exact length of a frame, that a frame launches as soon as a word waits, that full and empty are never set together, and that the overflow flag only rises from a strobe into a full queue and then stays set. Only the bench scenarios can show the serial content: the zero reserved bits, the bit order, the order of words across bursts, the launch delay from the strobe, the spacing between frames, and that a dropped word never appears on the line. To show these, a bench receiver decodes every frame.

// File: rtl/ttq_pkg.sv
package ttq_pkg;
  localparam int TYPE_W  = 8;
  localparam int WORD_W  = 10;
  localparam int RSV_W   = WORD_W - TYPE_W;
  localparam int FRAME_W = WORD_W + 2;

  typedef logic [WORD_W-1:0] tword_t;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  function automatic tword_t widen_type(input logic [TYPE_W-1:0] b);
    return {{RSV_W{1'b0}}, b};
  endfunction
endpackage

// File: rtl/ttq_rst_sync.sv
module ttq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/ttq_fifo.sv
module ttq_fifo
  import ttq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  tword_t din,
  input  logic   pop,
  output tword_t dout,
  output logic   empty,
  output logic   full,
  output logic   drop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  tword_t           mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             push_ok, pop_ok;

  assign empty   = (count_q == '0);
  assign full    = (count_q == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign drop    = push && full;
  assign dout    = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
    end
    unique case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + CNT_W'(1);
      2'b01:   count_d = count_q - CNT_W'(1);
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr_q] <= din;
    end
  end
endmodule

// File: rtl/ttq_framer.sv
module ttq_framer
  import ttq_pkg::*;
#(
  parameter int BIT_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   avail,
  input  tword_t word,
  output logic   pop,
  output logic   ser_out,
  output logic   busy
);
  localparam int DIV_W = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam int BIT_W = $clog2(FRAME_W);

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic               bit_end;

  assign bit_end = (div_q == DIV_W'(BIT_CYCLES - 1));
  assign pop     = (state_q == TX_IDLE) && avail;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    div_d   = div_q;
    bit_d   = bit_q;
    unique case (state_q)
      TX_IDLE: begin
        if (avail) begin
          state_d = TX_SEND;
          shreg_d = {1'b0, word, 1'b1};
          div_d   = '0;
          bit_d   = '0;
        end
      end
      TX_SEND: begin
        if (bit_end) begin
          div_d   = '0;
          shreg_d = {shreg_q[FRAME_W-2:0], 1'b1};
          if (bit_q == BIT_W'(FRAME_W - 1)) begin
            state_d = TX_IDLE;
          end else begin
            bit_d = bit_q + BIT_W'(1);
          end
        end else begin
          div_d = div_q + DIV_W'(1);
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      shreg_q <= '1;
      div_q   <= '0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
    end
  end

  assign ser_out = shreg_q[FRAME_W-1];
  assign busy    = (state_q == TX_SEND);
endmodule

// File: rtl/trig_type_tx.sv
module trig_type_tx
  import ttq_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int BIT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              type_valid,
  input  logic [TYPE_W-1:0] type_byte,
  output logic              ser_out,
  output logic              tx_busy,
  output logic              q_empty,
  output logic              q_full,
  output logic              overflow
);
  logic   rst_i_n;
  logic   pop, drop;
  tword_t head_word;
  logic   ovf_q, ovf_d;

  ttq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ttq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_i_n),
    .push  (type_valid),
    .din   (widen_type(type_byte)),
    .pop   (pop),
    .dout  (head_word),
    .empty (q_empty),
    .full  (q_full),
    .drop  (drop)
  );

  ttq_framer #(.BIT_CYCLES(BIT_CYCLES)) u_framer (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .avail   (!q_empty),
    .word    (head_word),
    .pop     (pop),
    .ser_out (ser_out),
    .busy    (tx_busy)
  );

  assign ovf_d = ovf_q | drop;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/ttq_checker.sv
module ttq_checker #(
  parameter int DEPTH      = 16,
  parameter int BIT_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic type_valid,
  input logic ser_out,
  input logic tx_busy,
  input logic q_empty,
  input logic q_full,
  input logic overflow
);
  localparam int FRAME_CYC = 12 * BIT_CYCLES;
  localparam int FULL_LVL  = DEPTH;

  logic [15:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_len_q <= '0;
    end else if (!tx_busy) begin
      busy_len_q <= '0;
    end else begin
      busy_len_q <= busy_len_q + 16'd1;
    end
  end

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_out);

  a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !ser_out);

  a_r4_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> (busy_len_q == 16'(FRAME_CYC)));

  a_r6_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (FULL_LVL > 0) |-> !(q_full && q_empty));

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r7_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(type_valid && q_full));

  a_r8_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_empty && !tx_busy) |=> tx_busy);
endmodule

bind trig_type_tx ttq_checker #(
  .DEPTH      (DEPTH),
  .BIT_CYCLES (BIT_CYCLES)
) u_ttq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .type_valid (type_valid),
  .ser_out    (ser_out),
  .tx_busy    (tx_busy),
  .q_empty    (q_empty),
  .q_full     (q_full),
  .overflow   (overflow)
);

// File: tb/tb_trig_type_tx.sv
`timescale 1ns/1ps
module tb_trig_type_tx;
  localparam int DEPTH = 16;
  localparam int DIV   = 4;
  localparam int NVEC  = 6;
  // {type byte, expected 10-bit word}
  localparam logic [17:0] VEC [NVEC] = '{
    {8'h00, 10'h000}, {8'hFF, 10'h0FF}, {8'hA5, 10'h0A5},
    {8'h5A, 10'h05A}, {8'h01, 10'h001}, {8'h80, 10'h080}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       type_valid = 1'b0;
  logic [7:0] type_byte = 8'h00;
  logic       ser_out, tx_busy, q_empty, q_full, overflow;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [9:0] rx_w [32];
  bit         rx_ok [32];
  int         rx_t [32];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trig_type_tx #(.DEPTH(DEPTH), .BIT_CYCLES(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .type_valid(type_valid), .type_byte(type_byte),
    .ser_out(ser_out), .tx_busy(tx_busy), .q_empty(q_empty),
    .q_full(q_full), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_one(input logic [7:0] b);
    type_valid = 1'b1;
    type_byte  = b;
    @(negedge clk);
    type_valid = 1'b0;
  endtask

  task automatic recv(input int idx);
    logic [11:0] f;
    int guard = 0;
    while (ser_out !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    rx_t[idx] = cyc;
    f[11] = ser_out;
    for (int k = 1; k < 12; k++) begin
      repeat (DIV) @(negedge clk);
      f[11-k] = ser_out;
    end
    rx_ok[idx] = (guard < 5000) && (f[11] == 1'b0) && (f[0] == 1'b1);
    rx_w[idx]  = f[10:1];
  endtask

  task automatic wait_idle();
    int g = 0;
    while ((tx_busy || !q_empty) && g < 5000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic run_burst(input int n_push, input int n_exp, input int seed,
                           input logic exp_ovf);
    fork
      begin
        for (int i = 0; i < n_push; i++) begin
          type_valid = 1'b1;
          type_byte  = 8'(i * 37 + seed);
          @(negedge clk);
        end
        type_valid = 1'b0;
        chk("R6 q_full after burst", 32'(q_full), 32'(1));
        chk("R7 overflow after burst", 32'(overflow), 32'(exp_ovf));
      end
      begin
        for (int j = 0; j < n_exp; j++) recv(j);
      end
    join
    for (int j = 0; j < n_exp; j++) begin
      chk("R4 burst framing", 32'(rx_ok[j]), 32'(1));
      chk("R5/R6 burst order", 32'(rx_w[j]), 32'({2'b00, 8'(j * 37 + seed)}));
      if (j > 0) chk("R9 frame spacing", 32'(rx_t[j] - rx_t[j-1]), 32'(12 * DIV + 1));
    end
  endtask

  initial begin
    bit stayed_high;
    @(negedge clk);
    // R1: state during reset
    chk("R1 ser_out in reset", 32'(ser_out), 32'(1));
    chk("R1 q_empty in reset", 32'(q_empty), 32'(1));
    chk("R1 q_full in reset", 32'(q_full), 32'(0));
    chk("R1 overflow in reset", 32'(overflow), 32'(0));
    chk("R1 tx_busy in reset", 32'(tx_busy), 32'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ser_out after reset", 32'(ser_out), 32'(1));
    chk("R2 idle line", 32'(ser_out), 32'(1));

    // R8: launch delay from an idle, empty queue
    push_one(8'h3C);
    chk("R8 line high one edge after strobe", 32'(ser_out), 32'(1));
    chk("R8 queue non-empty after strobe", 32'(q_empty), 32'(0));
    @(negedge clk);
    chk("R8 start bit after second edge", 32'(ser_out), 32'(0));
    recv(0);
    chk("R4 framing first word", 32'(rx_ok[0]), 32'(1));
    chk("R3 first word", 32'(rx_w[0]), 32'(10'h03C));
    wait_idle();

    // vector table: single words, R3 R4 R2
    for (int v = 0; v < NVEC; v++) begin
      push_one(VEC[v][17:10]);
      recv(0);
      chk("R4 framing vector", 32'(rx_ok[0]), 32'(1));
      chk("R3 word vector", 32'(rx_w[0]), 32'(VEC[v][9:0]));
      wait_idle();
      chk("R2 idle after frame", 32'(ser_out), 32'(1));
    end

    // R6: burst of DEPTH+1 back-to-back strobes, nothing lost
    run_burst(DEPTH + 1, DEPTH + 1, 5, 1'b0);
    wait_idle();
    chk("R6 queue drained", 32'(q_empty), 32'(1));

    // R7: burst of DEPTH+4, three dropped
    run_burst(DEPTH + 4, DEPTH + 1, 11, 1'b1);
    stayed_high = 1'b1;
    for (int c = 0; c < 30 * DIV; c++) begin
      @(negedge clk);
      if (ser_out !== 1'b1) stayed_high = 1'b0;
    end
    chk("R7 dropped words never sent", 32'(stayed_high), 32'(1));
    chk("R7 overflow sticky", 32'(overflow), 32'(1));

    // reset clears sticky flag
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 overflow cleared by reset", 32'(overflow), 32'(0));
    chk("R1 q_empty on reset", 32'(q_empty), 32'(1));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 overflow stays clear after reset", 32'(overflow), 32'(0));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule